// File: doc/BRIEF.md
# Memory-mapped flash read engine

This block turns single-word read requests from a simple on-chip bus into complete serial flash read transactions. Each accepted request lowers chip select, sends a read opcode, sends the byte address formed from the requested word address, inserts a number of dummy bytes, and then shifts in four data bytes. The bytes come back as one 32-bit word, flagged by a one-cycle valid pulse.

A 16-bit configuration word selects the opcode, the dummy-byte count and the interface type. The interface type sets how many data lines carry the address, dummy and data phases. A separate input selects 3-byte or 4-byte addressing. All of these are captured when a request is accepted, so they may change while a transaction is in flight.

The serial clock idles low and runs at half the system clock rate. A run input acts as a soft reset. While it is low the engine stays idle, drops any transaction in progress and accepts nothing.

Top module: `flash_rd_eng`

## Requirements
- R1: `ready_o` is high only when `run_i` is high and no transaction is in flight. A request is accepted in a cycle where `req_i` and `ready_o` are both high, and chip select goes low in the next cycle. `ready_o` stays low from then until the cycle after the valid pulse.
- R2: During a transaction `cs_no` is low throughout, and `sck_o` is low whenever `cs_no` is high. The first 8 serial clocks carry the opcode `cfg_i[15:8]` on `io_o[0]`, most significant bit first, always on one line. The flash samples on the rising edge.
- R3: The address sent is the byte address `{req_addr_i, 2'b00}`, most significant bit first. Only its low 24 bits are sent when `addr4_i` is 0, and all 32 bits when it is 1.
- R4: `cfg_i[2:0]` sets the line count for the address, dummy and data phases. Code 0 uses one line: output on `io_o[0]`, input on `io_i[1]`. Codes 1 and 2 use two lines on `io[1:0]`. Codes 3 and 4 use four lines on `io[3:0]`. Codes 5 to 7 behave as code 0. Within a clock, the higher line index carries the more significant bit.
- R5: `cfg_i[5:3]` gives D dummy bytes, which take D*8/lines serial clocks. During the dummy phase `io_oe_o` is 4'b0001 in one-line mode and 4'b0000 otherwise. Each serial clock spans two system cycles, and a transaction has exactly 8 + address bits/lines + D*8/lines + 32/lines rising edges.
- R6: Data bits arrive most significant bit first within each byte. The first byte received is placed in `rdata_o[7:0]` and the fourth in `rdata_o[31:24]`. `rvalid_o` is high for exactly one cycle, with `cs_no` already high.
- R7: `cfg_i[7:6]` (prefetch count) has no effect on the transaction or on the returned data.
- R8: While `run_i` is low, the engine returns to idle on the next clock edge (`cs_no` high, `sck_o` low, no valid pulse), `ready_o` is low, and requests are ignored. Once `run_i` is high again, the engine accepts requests normally.
- R9: `cfg_i`, `addr4_i` and `req_addr_i` are sampled only in the accepting cycle. Changing them later has no effect on the transaction in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Soft-reset control, engine runs while high |
| addr4_i | input | 1 | 1 selects 4-byte addressing, 0 selects 3-byte |
| cfg_i | input | 16 | [2:0] interface type, [5:3] dummy bytes, [7:6] prefetch (unused), [15:8] opcode |
| req_i | input | 1 | Read request |
| req_addr_i | input | AW | Word address of the request |
| ready_o | output | 1 | Engine idle and able to accept a request |
| rdata_o | output | 32 | Returned word, valid with rvalid_o |
| rvalid_o | output | 1 | One-cycle pulse marking returned data |
| cs_no | output | 1 | Flash chip select, active low |
| sck_o | output | 1 | Serial clock, idles low |
| io_o | output | 4 | Serial data out on lines 3..0 |
| io_oe_o | output | 4 | Output enable for each line |
| io_i | input | 4 | Serial data in on lines 3..0 |

## Verification
The bench builds the engine with the default AW of 30. With that width, the upper byte of the 4-byte address comes from real request bits, and 4-byte mode can be told apart from 3-byte mode. The configuration space is small enough to sweep in full: all eight interface codes, both address modes and every dummy count from 0 to 7. The bench models the flash, which decodes the opcode and address, checks the released lines during the dummy phase and drives data bytes computed from the address. The sweep also scrambles the inputs after each accept, and separate runs cover the prefetch field and an abort through the run input.

// File: rtl/flash_rd_pkg.sv
package flash_rd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_CMD, ST_ADDR, ST_DUMMY, ST_DATA, ST_END
  } st_e;

  // log2 of line count for an interface code
  function automatic logic [1:0] lane_shift(input logic [2:0] code);
    case (code)
      3'd1, 3'd2: return 2'd1;
      3'd3, 3'd4: return 2'd2;
      default:    return 2'd0;
    endcase
  endfunction

  function automatic logic [3:0] lane_mask(input logic [1:0] lsh);
    case (lsh)
      2'd1:    return 4'b0011;
      2'd2:    return 4'b1111;
      default: return 4'b0001;
    endcase
  endfunction
endpackage

// File: rtl/flash_rd_seq.sv
module flash_rd_seq
  import flash_rd_pkg::*;
#(
  parameter int MAX_DUMMY = 7
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic       req_i,
  input  logic [2:0] dummy_i,
  input  logic [1:0] lsh_i,
  input  logic       addr4_i,
  output logic       ready_o,
  output logic       accept_o,
  output st_e        st_o,
  output logic       ph_o,
  output logic       step_o,
  output logic [1:0] lsh_o,
  output logic       done_o
);
  localparam int MAX_STEPS = MAX_DUMMY * 8;
  localparam int CNT_W     = $clog2(MAX_STEPS + 1);

  st_e              st_q, st_d;
  logic             ph_q, done_q, a4_q, active, last;
  logic [CNT_W-1:0] cnt_q, cnt_d, addr_steps, dummy_steps, data_steps;
  logic [2:0]       dum_q;
  logic [1:0]       lsh_q;

  assign active   = st_q inside {ST_CMD, ST_ADDR, ST_DUMMY, ST_DATA};
  assign ready_o  = run_i && (st_q == ST_IDLE);
  assign accept_o = ready_o && req_i;
  assign step_o   = active && ph_q;
  assign last     = cnt_q == CNT_W'(1);

  assign addr_steps  = CNT_W'((a4_q ? 32 : 24) >> lsh_q);
  assign dummy_steps = CNT_W'((int'(dum_q) * 8) >> lsh_q);
  assign data_steps  = CNT_W'(32 >> lsh_q);

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    if (step_o && !last) cnt_d = cnt_q - CNT_W'(1);
    unique case (st_q)
      ST_IDLE: if (accept_o) begin st_d = ST_CMD; cnt_d = CNT_W'(8); end
      ST_CMD:  if (step_o && last) begin st_d = ST_ADDR; cnt_d = addr_steps; end
      ST_ADDR: if (step_o && last) begin
        if (dum_q != 3'd0) begin st_d = ST_DUMMY; cnt_d = dummy_steps; end
        else               begin st_d = ST_DATA;  cnt_d = data_steps;  end
      end
      ST_DUMMY: if (step_o && last) begin st_d = ST_DATA; cnt_d = data_steps; end
      ST_DATA:  if (step_o && last) st_d = ST_END;
      ST_END:   st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      ph_q   <= 1'b0;
      cnt_q  <= '0;
      done_q <= 1'b0;
      dum_q  <= '0;
      lsh_q  <= '0;
      a4_q   <= 1'b0;
    end else if (!run_i) begin
      st_q   <= ST_IDLE;
      ph_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      ph_q   <= active ? ~ph_q : 1'b0;
      done_q <= (st_q == ST_DATA) && step_o && last;
      if (accept_o) begin
        dum_q <= dummy_i;
        lsh_q <= lsh_i;
        a4_q  <= addr4_i;
      end
    end
  end

  assign st_o   = st_q;
  assign ph_o   = ph_q;
  assign lsh_o  = lsh_q;
  assign done_o = done_q;
endmodule

// File: rtl/flash_rd_tx.sv
module flash_rd_tx
  import flash_rd_pkg::*;
#(
  parameter int OP_W = 8,
  parameter int BA_W = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            accept_i,
  input  logic [OP_W-1:0] op_i,
  input  logic [BA_W-1:0] baddr_i,
  input  logic            addr4_i,
  input  st_e             st_i,
  input  logic [1:0]      lsh_i,
  input  logic            step_i,
  output logic [3:0]      io_o,
  output logic [3:0]      io_oe_o
);
  localparam int SH_W = OP_W + BA_W;

  logic [SH_W-1:0] sh_q;
  logic [2:0]      lanes;

  assign lanes = 3'd1 << lsh_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else if (accept_i)
      sh_q <= addr4_i ? {op_i, baddr_i} : {op_i, baddr_i[23:0], 8'h00};
    else if (step_i && st_i == ST_CMD)  sh_q <= sh_q << 1;
    else if (step_i && st_i == ST_ADDR) sh_q <= sh_q << lanes;
  end

  always_comb begin
    io_o    = 4'b0000;
    io_oe_o = 4'b0000;
    case (st_i)
      ST_CMD: begin
        io_o    = {3'b000, sh_q[SH_W-1]};
        io_oe_o = 4'b0001;
      end
      ST_ADDR: begin
        case (lsh_i)
          2'd1:    io_o = {2'b00, sh_q[SH_W-1 -: 2]};
          2'd2:    io_o = sh_q[SH_W-1 -: 4];
          default: io_o = {3'b000, sh_q[SH_W-1]};
        endcase
        io_oe_o = lane_mask(lsh_i);
      end
      ST_DUMMY, ST_DATA: io_oe_o = (lsh_i == 2'd0) ? 4'b0001 : 4'b0000;
      default: ;
    endcase
  end
endmodule

// File: rtl/flash_rd_rx.sv
module flash_rd_rx #(
  parameter int BYTES = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sample_i,
  input  logic [1:0]         lsh_i,
  input  logic [3:0]         io_i,
  output logic [8*BYTES-1:0] rdata_o
);
  localparam int W = 8 * BYTES;

  logic [W-1:0] rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rx_q <= '0;
    else if (sample_i) begin
      case (lsh_i)
        2'd1:    rx_q <= {rx_q[W-3:0], io_i[1:0]};
        2'd2:    rx_q <= {rx_q[W-5:0], io_i};
        default: rx_q <= {rx_q[W-2:0], io_i[1]};
      endcase
    end
  end

  // first byte received lands in the low byte
  for (genvar b = 0; b < BYTES; b++) begin : g_swap
    assign rdata_o[8*b +: 8] = rx_q[W-1-8*b -: 8];
  end
endmodule

// File: rtl/flash_rd_eng.sv
module flash_rd_eng
  import flash_rd_pkg::*;
#(
  parameter int AW = 30
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          addr4_i,
  input  logic [15:0]   cfg_i,
  input  logic          req_i,
  input  logic [AW-1:0] req_addr_i,
  output logic          ready_o,
  output logic [31:0]   rdata_o,
  output logic          rvalid_o,
  output logic          cs_no,
  output logic          sck_o,
  output logic [3:0]    io_o,
  output logic [3:0]    io_oe_o,
  input  logic [3:0]    io_i
);
  st_e         st;
  logic        accept, ph, step;
  logic [1:0]  lsh;
  logic [31:0] baddr;
  logic        unused_pf;

  assign baddr     = 32'({req_addr_i, 2'b00});
  assign unused_pf = ^cfg_i[7:6];

  flash_rd_seq u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run_i),
    .req_i   (req_i),
    .dummy_i (cfg_i[5:3]),
    .lsh_i   (lane_shift(cfg_i[2:0])),
    .addr4_i (addr4_i),
    .ready_o (ready_o),
    .accept_o(accept),
    .st_o    (st),
    .ph_o    (ph),
    .step_o  (step),
    .lsh_o   (lsh),
    .done_o  (rvalid_o)
  );

  flash_rd_tx u_tx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .accept_i(accept),
    .op_i    (cfg_i[15:8]),
    .baddr_i (baddr),
    .addr4_i (addr4_i),
    .st_i    (st),
    .lsh_i   (lsh),
    .step_i  (step),
    .io_o    (io_o),
    .io_oe_o (io_oe_o)
  );

  flash_rd_rx u_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sample_i(step && st == ST_DATA),
    .lsh_i   (lsh),
    .io_i    (io_i),
    .rdata_o (rdata_o)
  );

  assign sck_o = ph;
  assign cs_no = !(st inside {ST_CMD, ST_ADDR, ST_DUMMY, ST_DATA});
endmodule

// File: rtl/flash_rd_eng_chk.sv
module flash_rd_eng_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       run_i,
  input logic       req_i,
  input logic       ready_o,
  input logic       rvalid_o,
  input logic       cs_no,
  input logic       sck_o,
  input logic [3:0] io_oe_o
);
  // R1
  busy_not_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_no |-> !ready_o);
  // R1
  accept_starts_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && ready_o |=> !cs_no);
  // R2
  sck_idle_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sck_o);
  // R5
  lines_released_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> io_oe_o == 4'b0000);
  // R6
  rvalid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |=> !rvalid_o);
  // R6
  rvalid_after_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> cs_no && !ready_o);
  // R8
  soft_rst_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> cs_no && !sck_o && !rvalid_o);
endmodule

bind flash_rd_eng flash_rd_eng_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .run_i   (run_i),
  .req_i   (req_i),
  .ready_o (ready_o),
  .rvalid_o(rvalid_o),
  .cs_no   (cs_no),
  .sck_o   (sck_o),
  .io_oe_o (io_oe_o)
);

// File: tb/flash_rd_eng_tb.sv
module flash_rd_eng_tb;
  localparam int AW = 30;

  logic          clk = 1'b0, rst_ni = 1'b0, run_i = 1'b1, addr4_i = 1'b0, req_i = 1'b0;
  logic [15:0]   cfg_i = '0;
  logic [AW-1:0] req_addr_i = '0;
  logic          ready_o, rvalid_o, cs_no, sck_o;
  logic [31:0]   rdata_o;
  logic [3:0]    io_o, io_oe_o;
  logic [3:0]    io_i = 4'b0000;

  always #2 clk = ~clk;

  flash_rd_eng #(.AW(AW)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .run_i(run_i), .addr4_i(addr4_i), .cfg_i(cfg_i),
    .req_i(req_i), .req_addr_i(req_addr_i), .ready_o(ready_o), .rdata_o(rdata_o),
    .rvalid_o(rvalid_o), .cs_no(cs_no), .sck_o(sck_o), .io_o(io_o), .io_oe_o(io_oe_o),
    .io_i(io_i)
  );

  int checks = 0, errors = 0;
  bit fin = 1'b0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] lmask(input int l);
    return 4'((1 << l) - 1);
  endfunction

  function automatic logic [7:0] bval(input logic [AW-1:0] wa, input int k);
    return 8'(32'(wa) * 3 + k * 69 + 28);
  endfunction

  // flash model
  int          m_l = 1, m_asteps = 24, m_dsteps = 0, m_data = 32;
  logic [31:0] m_stream = '0;
  int          edges = 0, oe_bad = 0;
  logic [7:0]  op_rx = '0;
  logic [31:0] ad_rx = '0;

  always @(negedge cs_no) begin
    edges = 0; op_rx = '0; ad_rx = '0; oe_bad = 0; io_i = 4'b0000;
  end

  always @(posedge sck_o) begin
    if (edges < 8) op_rx = {op_rx[6:0], io_o[0]};
    else if (edges < 8 + m_asteps) ad_rx = (ad_rx << m_l) | 32'(io_o & lmask(m_l));
    else if (edges < 8 + m_asteps + m_dsteps) begin
      if (io_oe_o != ((m_l == 1) ? 4'b0001 : 4'b0000)) oe_bad++;
    end
    edges++;
  end

  always @(negedge sck_o) begin
    int j;
    j = edges - (8 + m_asteps + m_dsteps);
    if (!cs_no && j >= 0 && j < m_data) begin
      logic [3:0] nib;
      nib = 4'((m_stream >> (32 - (j + 1) * m_l)) & ((1 << m_l) - 1));
      io_i = (m_l == 1) ? {2'b00, nib[0], 1'b0} : nib;
    end
  end

  task automatic do_read(input int code, input int dum, input bit a4, input logic [7:0] op,
                         input logic [AW-1:0] wa, input logic [1:0] pf,
                         output logic [31:0] got, output int got_edges);
    logic [31:0] baddr, aexp, dexp;
    int n, tot;
    m_l      = (code == 1 || code == 2) ? 2 : (code == 3 || code == 4) ? 4 : 1;
    m_asteps = (a4 ? 32 : 24) / m_l;
    m_dsteps = dum * 8 / m_l;
    m_data   = 32 / m_l;
    tot      = 8 + m_asteps + m_dsteps + m_data;
    m_stream = {bval(wa, 0), bval(wa, 1), bval(wa, 2), bval(wa, 3)};
    dexp     = {bval(wa, 3), bval(wa, 2), bval(wa, 1), bval(wa, 0)};
    baddr    = 32'({wa, 2'b00});
    aexp     = a4 ? baddr : {8'h00, baddr[23:0]};
    @(negedge clk);
    check(ready_o == 1'b1, "R1 ready when idle", 32'(ready_o), 32'd1);
    cfg_i = {op, pf, 3'(dum), 3'(code)}; addr4_i = a4; req_addr_i = wa; req_i = 1'b1;
    @(negedge clk);
    // R9: scramble inputs once accepted
    req_i = 1'b0; cfg_i = ~cfg_i; addr4_i = ~a4; req_addr_i = ~wa;
    check(!ready_o && !cs_no, "R1 busy after accept", 32'({ready_o, cs_no}), 32'd0);
    n = 0;
    while (!rvalid_o && n < 2000) begin
      @(negedge clk);
      n++;
    end
    got = rdata_o;
    got_edges = edges;
    check(rvalid_o && cs_no, "R6 valid with cs released", 32'({rvalid_o, cs_no}), 32'd3);
    check(op_rx == op, "R2 opcode", 32'(op_rx), 32'(op));
    check(ad_rx == aexp, "R3 address", ad_rx, aexp);
    check(edges == tot, "R5 serial clock count", 32'(edges), 32'(tot));
    check(oe_bad == 0, "R5 lines during dummy", 32'(oe_bad), 32'd0);
    check(rdata_o == dexp, "R4 R6 R9 returned word", rdata_o, dexp);
    @(negedge clk);
    check(!rvalid_o && ready_o, "R6 single pulse then R1 ready", 32'({rvalid_o, ready_o}), 32'd1);
  endtask

  initial begin
    logic [31:0] r0, r1;
    int e0, e1;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check(cs_no && !sck_o && !rvalid_o, "R2 reset idle",
          32'({cs_no, sck_o, rvalid_o}), 32'd4);
    check(ready_o && io_oe_o == 4'b0000, "R1 reset ready",
          32'({ready_o, io_oe_o}), 32'h10);

    for (int c = 0; c < 8; c++)
      for (int a = 0; a < 2; a++)
        for (int d = 0; d < 8; d++) begin
          int idx;
          idx = c * 16 + a * 8 + d;
          do_read(c, d, a[0], 8'(3 + idx * 29), AW'(30'h2A5C3F1 + idx * 30'h01010B3),
                  2'(idx), r0, e0);
        end

    // R7: prefetch field must not change anything
    do_read(3, 2, 1'b1, 8'hEB, AW'(30'h3F00A55), 2'b00, r0, e0);
    do_read(3, 2, 1'b1, 8'hEB, AW'(30'h3F00A55), 2'b11, r1, e1);
    check(r0 == r1, "R7 prefetch data", r1, r0);
    check(e0 == e1, "R7 prefetch clocks", 32'(e1), 32'(e0));

    // R8: abort a transaction through the run input
    @(negedge clk);
    cfg_i = {8'h6B, 2'b00, 3'd3, 3'd3}; addr4_i = 1'b0; req_addr_i = AW'(30'h1234); req_i = 1'b1;
    @(negedge clk);
    req_i = 1'b0;
    repeat (10) @(negedge clk);
    check(!cs_no, "R8 transaction in flight", 32'(cs_no), 32'd0);
    run_i = 1'b0;
    @(negedge clk);
    check(cs_no && !sck_o && !ready_o, "R8 abort to idle",
          32'({cs_no, sck_o, ready_o}), 32'd4);
    req_i = 1'b1;
    repeat (6) begin
      @(negedge clk);
      check(cs_no && !rvalid_o && !ready_o, "R8 request ignored",
            32'({cs_no, rvalid_o, ready_o}), 32'd4);
    end
    req_i = 1'b0;
    run_i = 1'b1;
    @(negedge clk);
    check(ready_o == 1'b1, "R8 ready after release", 32'(ready_o), 32'd1);
    do_read(4, 1, 1'b0, 8'hEC, AW'(30'h0777777), 2'b01, r0, e0);

    fin = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!fin) begin
      errors++;
      checks++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule